// File: doc/BRIEF.md
# Shared Ingress Rate Bucket with Flow Control

This block is a single ingress rate-limiting bucket that any subset of a switch's ingress ports can share. Each port carries a membership bit for this bucket. Frames accepted on a member port, and matching the bucket's traffic selection, are charged to a fill level. The charge is the frame length plus a per-bucket byte adjustment, multiplied by a bucket increment. The fill level drains by a rate factor on every time-update tick and never goes below zero.

The fill level is checked against an excess limit on every frame. In drop mode, a frame that would push the level above that limit is discarded and not charged. In pause mode, the frame is charged and pause is raised on every member port. Each port chooses when its pause is released: either when the bucket runs empty, or when the level has fallen to the committed limit.

A unit-initialise pulse returns the bucket to empty with all pause outputs released. Two configuration words are decoded by bit position, so existing register layouts can drive them directly.

Top module: `rib_bucket`

## Requirements
- R1: Reset, or a cycle with `unit_init` high, leaves `fill_level` at 0, `pause` all 0 and `frm_drop` at 0 on the following cycle.
- R2: An eligible frame adds (`frm_len` + `cfg_mode[3:0]`) × `cfg_incr` to `fill_level`. The new value is visible on the cycle after `frm_valid`.
- R3: A cycle with `tick` high subtracts `cfg_rate` from the level, stopping at 0. Without a charged frame the level never rises.
- R4: A frame from a port whose `port_member` bit is 0 is neither charged nor dropped.
- R5: When `cfg_mode[15]` is 0 (traffic-selective), a frame is charged only if `cfg_mode[4+frm_type]` is set; types 11 to 15 are never charged. When `cfg_mode[15]` is 1, every type is charged.
- R6: When `cfg_action[12]` is 0 (drop), an eligible frame whose charge would take the level above `cfg_ebs` gives `frm_drop` high on the next cycle and leaves the level unchanged by that frame.
- R7: When `cfg_action[12]` is 1 (pause), such a frame is charged, `frm_drop` stays low, and every member port's `pause` goes high on the next cycle.
- R8: A paused port with `fc_rel_mode` bit 0 releases on the cycle the level becomes 0.
- R9: A paused port with `fc_rel_mode` bit 1 releases on the cycle the level becomes less than or equal to `cfg_cbs`.
- R10: A frame flagged `frm_filtered` is charged only if `cfg_action[14]` is 1. A frame flagged `frm_qcong` is charged only if `cfg_action[15]` is 1.
- R11: The level saturates at 2^FILL_W−1 instead of wrapping.
- R12: Clearing a port's membership bit releases that port's pause on the next cycle.
- R13: When a tick and a frame arrive in the same cycle, the drain is applied first and the frame is compared against the drained level. A level exactly equal to `cfg_ebs` is not over the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_init | input | 1 | Clears the bucket and all pause outputs |
| tick | input | 1 | Time-update strobe (drain) |
| cfg_mode | input | 16 | [15] rate-based, [14:4] type mask, [3:0] byte adjustment |
| cfg_incr | input | 12 | Bucket increment per byte |
| cfg_rate | input | 16 | Drain amount per tick |
| cfg_cbs | input | 24 | Committed limit (release level) |
| cfg_ebs | input | 24 | Excess limit |
| cfg_action | input | 16 | [12] pause mode, [14] charge filtered, [15] charge queue-congested |
| port_member | input | NPORT | Per-port membership in this bucket |
| fc_rel_mode | input | NPORT | Per-port release: 0 at empty, 1 at committed limit |
| frm_valid | input | 1 | Frame accept event |
| frm_port | input | PW | Ingress port of the frame |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_type | input | 4 | Traffic-type index |
| frm_filtered | input | 1 | Frame was filtered |
| frm_qcong | input | 1 | Frame hit queue congestion |
| frm_drop | output | 1 | Frame discarded (cycle after event) |
| pause | output | NPORT | Per-port pause request |
| fill_level | output | FILL_W | Current bucket level |

## Verification
A corrupted fill level shows on `fill_level` one cycle after the event that produced it. It then drives the wrong decision on the next frame that nears the excess limit: a drop that should not happen, or a missing one. A wrong pause flop shows on `pause` right away, or stays stuck through the drain ticks that should release it, so release in either mode is checked on the exact tick that crosses the threshold. The bench runs a cycle-accurate model next to the design and compares all three outputs on every cycle, so any difference is reported within one cycle.

// File: rtl/rib_pkg.sv
package rib_pkg;

    localparam int MODE_RATE_BIT  = 15;
    localparam int MODE_MASK_LSB  = 4;
    localparam int MODE_MASK_W    = 11;
    localparam int MODE_ADJ_W     = 4;
    localparam int ACT_PAUSE_BIT  = 12;
    localparam int ACT_FILT_BIT   = 14;
    localparam int ACT_QCONG_BIT  = 15;

    typedef enum logic { LIMIT_DROP = 1'b0, LIMIT_PAUSE = 1'b1 } limit_act_e;
    typedef enum logic { REL_AT_EMPTY = 1'b0, REL_AT_CBS = 1'b1 } rel_mode_e;

    typedef struct packed {
        logic                   rate_based;
        logic [MODE_MASK_W-1:0] type_mask;
        logic [MODE_ADJ_W-1:0]  byte_adj;
        limit_act_e             action;
        logic                   charge_filt;
        logic                   charge_qcong;
    } bucket_cfg_t;

    function automatic bucket_cfg_t decode_cfg(input logic [15:0] mode_w,
                                               input logic [15:0] act_w);
        bucket_cfg_t c;
        c.rate_based   = mode_w[MODE_RATE_BIT];
        c.type_mask    = mode_w[MODE_MASK_LSB +: MODE_MASK_W];
        c.byte_adj     = mode_w[MODE_ADJ_W-1:0];
        c.action       = limit_act_e'(act_w[ACT_PAUSE_BIT]);
        c.charge_filt  = act_w[ACT_FILT_BIT];
        c.charge_qcong = act_w[ACT_QCONG_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rib_charge.sv
module rib_charge
    import rib_pkg::*;
#(
    parameter int LEN_W = 14,
    parameter int INC_W = 12,
    localparam int CHG_W = LEN_W + 1 + INC_W
) (
    input  bucket_cfg_t      cfg,
    input  logic             frm_valid,
    input  logic             member_hit,
    input  logic [3:0]       frm_type,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_filtered,
    input  logic             frm_qcong,
    input  logic [INC_W-1:0] incr,
    output logic             eligible,
    output logic [CHG_W-1:0] charge
);
    logic [15:0]      mask_pad;
    logic             type_ok;
    logic             acct_ok;
    logic [LEN_W:0]   bytes;

    always_comb begin
        mask_pad = {{(16-MODE_MASK_W){1'b0}}, cfg.type_mask};
        type_ok  = cfg.rate_based | mask_pad[frm_type];
        acct_ok  = (!frm_filtered || cfg.charge_filt) && (!frm_qcong || cfg.charge_qcong);
        eligible = frm_valid && member_hit && type_ok && acct_ok;
        bytes    = (LEN_W+1)'(frm_len) + (LEN_W+1)'(cfg.byte_adj);
        charge   = CHG_W'(bytes) * CHG_W'(incr);
    end
endmodule

// File: rtl/rib_drain.sv
module rib_drain #(
    parameter int FILL_W = 28,
    parameter int RATE_W = 16
) (
    input  logic [FILL_W-1:0] level,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [FILL_W-1:0] drained
);
    logic [FILL_W-1:0] rate_ext;

    always_comb begin
        rate_ext = FILL_W'(rate);
        if (!tick)
            drained = level;
        else if (level > rate_ext)
            drained = level - rate_ext;
        else
            drained = '0;
    end
endmodule

// File: rtl/rib_fc_port.sv
module rib_fc_port
    import rib_pkg::*;
#(
    parameter int FILL_W = 28,
    parameter int LIM_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_init,
    input  logic              member,
    input  rel_mode_e         rel_mode,
    input  logic              set_pause,
    input  logic [FILL_W-1:0] level_next,
    input  logic [LIM_W-1:0]  cbs,
    output logic              pause
);
    logic pause_d, pause_q;
    logic release_ok;

    always_comb begin
        if (rel_mode == REL_AT_CBS)
            release_ok = level_next <= FILL_W'(cbs);
        else
            release_ok = level_next == '0;

        pause_d = pause_q;
        if (unit_init || !member)
            pause_d = 1'b0;
        else if (set_pause)
            pause_d = 1'b1;
        else if (pause_q && release_ok)
            pause_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pause_q <= 1'b0;
        else        pause_q <= pause_d;
    end

    assign pause = pause_q;
endmodule

// File: rtl/rib_bucket.sv
module rib_bucket
    import rib_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int LEN_W  = 14,
    parameter int INC_W  = 12,
    parameter int RATE_W = 16,
    parameter int LIM_W  = 24,
    parameter int FILL_W = 28,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CHG_W = LEN_W + 1 + INC_W,
    localparam int SUM_W = ((FILL_W > CHG_W) ? FILL_W : CHG_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_init,
    input  logic              tick,
    input  logic [15:0]       cfg_mode,
    input  logic [INC_W-1:0]  cfg_incr,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [LIM_W-1:0]  cfg_cbs,
    input  logic [LIM_W-1:0]  cfg_ebs,
    input  logic [15:0]       cfg_action,
    input  logic [NPORT-1:0]  port_member,
    input  logic [NPORT-1:0]  fc_rel_mode,
    input  logic              frm_valid,
    input  logic [PW-1:0]     frm_port,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [3:0]        frm_type,
    input  logic              frm_filtered,
    input  logic              frm_qcong,
    output logic              frm_drop,
    output logic [NPORT-1:0]  pause,
    output logic [FILL_W-1:0] fill_level
);
    localparam logic [FILL_W-1:0] FILL_MAX = '1;

    typedef struct packed {
        logic [FILL_W-1:0] level;
        logic              drop;
    } bkt_state_t;

    bucket_cfg_t       cfg;
    bkt_state_t        st_d, st_q;
    logic [2**PW-1:0]  member_pad;
    logic              member_hit;
    logic              eligible;
    logic [CHG_W-1:0]  charge;
    logic [FILL_W-1:0] drained;
    logic [SUM_W-1:0]  sum;
    logic [FILL_W-1:0] sat_sum;
    logic              over;
    logic              set_pause;

    assign cfg        = decode_cfg(cfg_mode, cfg_action);
    assign member_pad = (2**PW)'(port_member);
    assign member_hit = member_pad[frm_port];

    rib_charge #(.LEN_W(LEN_W), .INC_W(INC_W)) u_charge (
        .cfg          (cfg),
        .frm_valid    (frm_valid),
        .member_hit   (member_hit),
        .frm_type     (frm_type),
        .frm_len      (frm_len),
        .frm_filtered (frm_filtered),
        .frm_qcong    (frm_qcong),
        .incr         (cfg_incr),
        .eligible     (eligible),
        .charge       (charge)
    );

    rib_drain #(.FILL_W(FILL_W), .RATE_W(RATE_W)) u_drain (
        .level   (st_q.level),
        .tick    (tick),
        .rate    (cfg_rate),
        .drained (drained)
    );

    always_comb begin
        sum       = SUM_W'(drained) + SUM_W'(charge);
        over      = eligible && (sum > SUM_W'(cfg_ebs));
        sat_sum   = (sum > SUM_W'(FILL_MAX)) ? FILL_MAX : sum[FILL_W-1:0];
        set_pause = over && (cfg.action == LIMIT_PAUSE) && !unit_init;

        st_d = st_q;
        if (unit_init) begin
            st_d.level = '0;
            st_d.drop  = 1'b0;
        end else begin
            st_d.drop = over && (cfg.action == LIMIT_DROP);
            if (eligible && !st_d.drop)
                st_d.level = sat_sum;
            else
                st_d.level = drained;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rib_fc_port #(.FILL_W(FILL_W), .LIM_W(LIM_W)) u_fc (
            .clk        (clk),
            .rst_n      (rst_n),
            .unit_init  (unit_init),
            .member     (port_member[p]),
            .rel_mode   (rel_mode_e'(fc_rel_mode[p])),
            .set_pause  (set_pause),
            .level_next (st_d.level),
            .cbs        (cfg_cbs),
            .pause      (pause[p])
        );
    end

    assign frm_drop   = st_q.drop;
    assign fill_level = st_q.level;
endmodule

// File: rtl/rib_bucket_chk.sv
module rib_bucket_chk #(
    parameter int NPORT  = 4,
    parameter int FILL_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unit_init,
    input logic              frm_valid,
    input logic [15:0]       cfg_action,
    input logic [NPORT-1:0]  port_member,
    input logic              frm_drop,
    input logic [NPORT-1:0]  pause,
    input logic [FILL_W-1:0] fill_level
);
    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        unit_init |=> (fill_level == '0 && pause == '0 && !frm_drop));

    p_idle_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_valid) |-> fill_level <= $past(fill_level));

    p_drop_needs_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_drop |-> ($past(frm_valid) && !$past(cfg_action[12])));

    p_drop_no_charge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_drop |-> fill_level <= $past(fill_level));

    p_pause_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pause & ~$past(pause)) != '0) |-> ($past(frm_valid) && $past(cfg_action[12])));

    p_pause_members_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pause & ~$past(port_member)) == '0);
endmodule

bind rib_bucket rib_bucket_chk #(.NPORT(NPORT), .FILL_W(FILL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_init   (unit_init),
    .frm_valid   (frm_valid),
    .cfg_action  (cfg_action),
    .port_member (port_member),
    .frm_drop    (frm_drop),
    .pause       (pause),
    .fill_level  (fill_level)
);

// File: tb/sim_rib_bucket.sv
`timescale 1ns/1ps
module sim_rib_bucket;
    localparam int NPORT = 4;
    localparam int LEN_W = 14;
    localparam int FILL_W = 28;
    localparam longint FMAX = (64'd1 << FILL_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unit_init, tick, frm_valid, frm_filtered, frm_qcong;
    logic [15:0] cfg_mode, cfg_action, cfg_rate;
    logic [11:0] cfg_incr;
    logic [23:0] cfg_cbs, cfg_ebs;
    logic [NPORT-1:0] port_member, fc_rel_mode;
    logic [1:0] frm_port;
    logic [LEN_W-1:0] frm_len;
    logic [3:0] frm_type;
    logic frm_drop;
    logic [NPORT-1:0] pause;
    logic [FILL_W-1:0] fill_level;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    longint m_fill = 0;
    logic [NPORT-1:0] m_pause = '0;
    bit m_drop = 0;

    always #5 clk = ~clk;

    rib_bucket u0 (
        .clk(clk), .rst_n(rst_n), .unit_init(unit_init), .tick(tick),
        .cfg_mode(cfg_mode), .cfg_incr(cfg_incr), .cfg_rate(cfg_rate),
        .cfg_cbs(cfg_cbs), .cfg_ebs(cfg_ebs), .cfg_action(cfg_action),
        .port_member(port_member), .fc_rel_mode(fc_rel_mode),
        .frm_valid(frm_valid), .frm_port(frm_port), .frm_len(frm_len),
        .frm_type(frm_type), .frm_filtered(frm_filtered), .frm_qcong(frm_qcong),
        .frm_drop(frm_drop), .pause(pause), .fill_level(fill_level)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of the requirements, one call per rising edge
    task automatic model_edge();
        longint drained, chg, sum;
        bit elig, over, type_ok;
        drained = m_fill;
        if (tick) drained = (m_fill > cfg_rate) ? m_fill - cfg_rate : 0;
        type_ok = cfg_mode[15] || (frm_type < 11 && cfg_mode[4 + frm_type]);
        elig = frm_valid && port_member[frm_port] && type_ok &&
               (!frm_filtered || cfg_action[14]) && (!frm_qcong || cfg_action[15]);
        chg = (longint'(frm_len) + cfg_mode[3:0]) * cfg_incr;
        sum = drained + chg;
        over = elig && (sum > cfg_ebs);
        if (unit_init) begin
            m_fill = 0; m_drop = 0; m_pause = '0;
        end else begin
            m_drop = over && !cfg_action[12];
            m_fill = (elig && !m_drop) ? ((sum > FMAX) ? FMAX : sum) : drained;
            for (int p = 0; p < NPORT; p++) begin
                if (!port_member[p]) m_pause[p] = 1'b0;
                else if (over && cfg_action[12]) m_pause[p] = 1'b1;
                else if (m_pause[p] && (fc_rel_mode[p] ? (m_fill <= cfg_cbs) : (m_fill == 0)))
                    m_pause[p] = 1'b0;
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (fill_level != m_fill || pause != m_pause || frm_drop != m_drop) begin
            errors++;
            $display("FAIL %s: actual fill=%0d pause=%b drop=%b expected fill=%0d pause=%b drop=%b",
                     tag, fill_level, pause, frm_drop, m_fill, m_pause, m_drop);
        end
        frm_valid = 0; tick = 0; unit_init = 0; frm_filtered = 0; frm_qcong = 0;
    endtask

    task automatic frame(input int port, input int len, input int typ);
        frm_valid = 1; frm_port = 2'(port); frm_len = LEN_W'(len); frm_type = 4'(typ);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        unit_init = 0; tick = 0; frm_valid = 0; frm_filtered = 0; frm_qcong = 0;
        frm_port = 0; frm_len = 0; frm_type = 0;
        cfg_mode = 16'h7FF2; cfg_action = 16'h0000; cfg_incr = 12'd1; cfg_rate = 16'd10;
        cfg_cbs = 24'd100; cfg_ebs = 24'd300;
        port_member = 4'b0011; fc_rel_mode = 4'b0010;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset fill", fill_level, 0);
        chk("R1 reset pause", pause, 0);
        chk("R1 reset drop", frm_drop, 0);

        frame(0, 50, 0); step("R2");
        chk("R2 charge len+adj", fill_level, 52);
        frame(2, 50, 0); step("R4");
        chk("R4 non-member ignored", fill_level, 52);
        tick = 1; step("R3");
        chk("R3 drain", fill_level, 42);

        cfg_mode = 16'h7F72;                 // type 3 bit cleared
        frame(1, 10, 3); step("R5");
        chk("R5 masked type", fill_level, 42);
        frame(1, 10, 12); step("R5");
        chk("R5 type above mask", fill_level, 42);
        cfg_mode = 16'hFF72;                 // rate-based
        frame(1, 10, 3); step("R5");
        chk("R5 rate-based charges all", fill_level, 54);

        frame(0, 10, 0); frm_filtered = 1; step("R10");
        chk("R10 filtered not charged", fill_level, 54);
        cfg_action = 16'h4000;
        frame(0, 10, 0); frm_filtered = 1; step("R10");
        chk("R10 filtered charged", fill_level, 66);
        frame(0, 10, 0); frm_qcong = 1; step("R10");
        chk("R10 qcong not charged", fill_level, 66);

        frame(0, 400, 0); step("R6");
        chk("R6 drop flag", frm_drop, 1);
        chk("R6 no charge", fill_level, 66);

        tick = 1; frame(0, 300 - 56 - 2, 0); step("R13");
        chk("R13 exactly ebs accepted", fill_level, 300);
        chk("R13 no drop", frm_drop, 0);

        cfg_action = 16'h1000;
        frame(1, 100, 0); step("R7");
        chk("R7 pause members", pause, 4'b0011);
        chk("R7 charged", fill_level, 402);
        chk("R7 no drop", frm_drop, 0);

        cfg_rate = 16'd50;
        while (m_fill > cfg_cbs) begin tick = 1; step("R9"); end
        chk("R9 cbs release port1 only", pause, 4'b0001);
        while (m_fill != 0) begin tick = 1; step("R8"); end
        chk("R8 empty release port0", pause, 4'b0000);

        frame(0, 400, 0); step("R7");
        port_member = 4'b0010; step("R12");
        chk("R12 member removal", pause, 4'b0010);
        port_member = 4'b0011;

        cfg_incr = 12'hFFF; cfg_mode = 16'hFF0F;
        for (int i = 0; i < 5; i++) begin frame(0, 16383, 0); step("R11"); end
        chk("R11 saturate", fill_level, FMAX);

        unit_init = 1; frame(0, 10, 0); step("R1");
        chk("R1 init fill", fill_level, 0);
        chk("R1 init pause", pause, 0);

        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                cfg_mode = 16'($urandom);
                cfg_action = 16'($urandom) & 16'hD000;
                cfg_incr = 12'($urandom_range(1, 20));
                cfg_rate = 16'($urandom_range(0, 3000));
                cfg_cbs = 24'($urandom_range(0, 20000));
                cfg_ebs = 24'($urandom_range(5000, 60000));
                fc_rel_mode = 4'($urandom);
            end
            if (c % 97 == 0) port_member = 4'($urandom);
            unit_init = ($urandom_range(0, 299) == 0);
            tick = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1)
                frame($urandom_range(0, 3), $urandom_range(0, 1500), $urandom_range(0, 15));
            frm_filtered = ($urandom_range(0, 7) == 0);
            frm_qcong = ($urandom_range(0, 7) == 0);
            step("random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule